// File: doc/BRIEF.md
# Watchdog Timer with Standby Wakeup

An 8-bit up-counter paired with an 8-bit control/status register. Both registers are loaded through one 16-bit write port. The upper byte of the write data is a key: a write goes through only when the key matches the register being written. The counter advances on single-cycle pulses from one of eight prescaler taps, and a 3-bit clock-select field chooses the tap.

During normal operation with the timer enabled, the block acts as a watchdog or as an interval timer. When the counter wraps, the block sets an overflow flag. It then raises either a reset request (watchdog mode) or an interval interrupt (interval mode).

The same counter also times clock settling when the chip leaves software standby. An interrupt edge starts the count. The wrap then raises a clock-restart request and leaves the overflow flag alone. Counting continues from zero. If the standby-enable input is still high when the count reaches 0x80, the block asks to go back into standby. If software drops standby-enable first, the counter stops.

The sequencer has four states:
- `ST_RUN`: normal operation.
- `ST_SLEEP`: standby, counter frozen.
- `ST_SETTLE`: settling count after a wake edge.
- `ST_WOKEN`: post-wake count toward 0x80.

Its transitions are:
- RUN→SLEEP when `stby_active` is high.
- SLEEP→RUN on `reset_wake`.
- SLEEP→SETTLE on a rising edge of `wake_req`.
- SETTLE→WOKEN when the counter wraps.
- WOKEN→RUN when `stby_enable` is low.
- WOKEN→SLEEP when the counter reaches 0x80.

Top module: `wdt_standby_timer`

## Requirements
- R1: A `cnt_wr` pulse loads `wdata[7:0]` into the counter only when `wdata[15:8]` is 0x5A. Any other key leaves the counter unchanged.
- R2: A `csr_wr` pulse updates the control/status register only when `wdata[15:8]` is 0xA5.
  - The field layout is bit 7 overflow flag, bit 6 mode (1 = watchdog, 0 = interval), bit 5 timer enable, and bits 2:0 clock select.
  - Bits 4:3 always read 0.
- R3: In `ST_RUN` with timer enable set, the counter advances by one for each pulse on `tap_pulse[cks]`. Pulses on other taps are ignored. With timer enable clear, the counter holds.
- R4: A normal wrap from 0xFF to 0x00 with timer enable set has two effects:
  - It sets the overflow flag.
  - In the cycle after the wrapping pulse, it raises a one-cycle `reset_req` in watchdog mode or a one-cycle `intv_irq` in interval mode.
- R5: The overflow flag is cleared by a keyed control/status write with bit 7 = 0. Writing 1 keeps its current value. A wrap in the same cycle as a clearing write leaves the flag set.
- R6: `stby_active` high in `ST_RUN` moves the block to `ST_SLEEP`. There the counter holds whatever the taps and timer enable do.
- R7: A rising edge on `wake_req` in `ST_SLEEP` starts the settling count on the selected tap. On the wrap, the block does all of the following:
  - It raises a one-cycle `clk_restart_req`.
  - It leaves the counter at 0x00.
  - It does not set the overflow flag.
  - It raises neither `reset_req` nor `intv_irq`.
- R8: After a settling wrap the counter keeps counting from 0x00. If `stby_enable` is high when it reaches 0x80, the block raises a one-cycle `restby_req` and returns to `ST_SLEEP` with the counter held at 0x80.
- R9: If `stby_enable` is low in `ST_WOKEN`, the counter stops and the block returns to `ST_RUN`.
- R10: A `reset_wake` pulse in `ST_SLEEP` returns the block to `ST_RUN` without the counter running.
- R11: After reset the following hold:
  - The counter and the control/status register are 0x00.
  - All four request outputs are low.
  - The state is `ST_RUN`.
- R12: A keyed counter write in the same cycle as a counting pulse takes the written value, and that pulse raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr | input | 1 | Write strobe for the counter |
| csr_wr | input | 1 | Write strobe for the control/status register |
| wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| tap_pulse | input | 8 | Single-cycle count pulses from the prescaler taps |
| wake_req | input | 1 | NMI / external interrupt request (rising edge wakes) |
| stby_active | input | 1 | Chip is entering or in software standby |
| stby_enable | input | 1 | Standby-enable control bit |
| reset_wake | input | 1 | Standby is being left through a reset |
| cnt_value | output | 8 | Current counter value |
| csr_value | output | 8 | Current control/status register value |
| clk_restart_req | output | 1 | One-cycle request to restart the clock |
| restby_req | output | 1 | One-cycle request to re-enter standby |
| reset_req | output | 1 | One-cycle watchdog reset request |
| intv_irq | output | 1 | One-cycle interval interrupt |

## Verification
Counting is driven with pulses on the selected tap and on a different tap, with timer enable on and off. This separates tap selection from enable gating. Wraps are produced in watchdog mode, in interval mode and in the settling phase. Each of these three is checked for which request fires and whether the overflow flag moves, which tells a normal wrap from a wakeup wrap.

The post-wake phase is run twice, once with standby-enable held high to 0x80 and once with it dropped. This separates the re-entry path from the stop path. Coincident pulses, such as a tap pulse with a counter write, or a wrap with a flag-clearing write, pin down the priority rules.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0] CNT_KEY = 8'h5A;
    localparam logic [7:0] CSR_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WOKEN  = 2'd3
    } wdt_state_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
    parameter int NUM_TAPS = 8,
    localparam int CKS_W   = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [CKS_W-1:0]    cks,
    input  logic                wake_in,
    output logic                tick,
    output logic                wake_edge
);
    logic wake_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_prev <= 1'b0;
        else        wake_prev <= wake_in;
    end

    assign tick      = taps[cks];
    assign wake_edge = wake_in & ~wake_prev;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int KEY_W = 8,
    parameter int CKS_W = 3,
    localparam int DATA_W = KEY_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              advance,
    input  logic              set_wovf,
    output logic              cnt_hit,
    output logic [CNT_W-1:0]  cnt,
    output logic              wovf,
    output logic              mode,
    output logic              tme,
    output logic [CKS_W-1:0]  cks
);
    logic             csr_hit;
    logic [CNT_W-1:0] lo;
    logic             unused_rsvd;

    assign lo          = wdata[CNT_W-1:0];
    assign cnt_hit     = cnt_wr && (wdata[DATA_W-1:CNT_W] == CNT_KEY);
    assign csr_hit     = csr_wr && (wdata[DATA_W-1:CNT_W] == CSR_KEY);
    assign unused_rsvd = ^lo[4:3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (cnt_hit) cnt <= lo;
        else if (advance) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wovf <= 1'b0;
            mode <= 1'b0;
            tme  <= 1'b0;
            cks  <= '0;
        end else begin
            if (csr_hit) begin
                mode <= lo[6];
                tme  <= lo[5];
                cks  <= lo[CKS_W-1:0];
            end
            if (set_wovf)      wovf <= 1'b1;
            else if (csr_hit)  wovf <= wovf & lo[7];
        end
    end

    // R1: a write with the wrong key and no count pulse leaves the counter alone
    assert_bad_key_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !cnt_hit && !advance) |=> (cnt == $past(cnt)));

    // R5: the flag only ever rises because the sequencer asked for it
    assert_wovf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wovf) |-> $past(set_wovf));
endmodule

// File: rtl/wdt_seq_fsm.sv
module wdt_seq_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam logic [CNT_W-1:0] MARK_M1 = {1'b0, {(CNT_W-1){1'b1}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_active,
    input  logic             stby_enable,
    input  logic             wake_edge,
    input  logic             rst_wake,
    input  logic             tick,
    input  logic             cnt_hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tme,
    input  logic             mode,
    output logic             run,
    output logic             advance,
    output logic             set_wovf,
    output wdt_state_e       state_q,
    output logic             clk_restart_req,
    output logic             restby_req,
    output logic             reset_req,
    output logic             intv_irq
);
    wdt_state_e state_d;
    logic       wrap, reach_mark;
    logic       ev_restart, ev_restby, ev_reset, ev_irq;

    assign advance    = run && tick && !cnt_hit;
    assign wrap       = advance && (cnt == '1);
    assign reach_mark = advance && (cnt == MARK_M1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stby_active) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (rst_wake)       state_d = ST_RUN;
                else if (wake_edge) state_d = ST_SETTLE;
            end
            ST_SETTLE: if (wrap) state_d = ST_WOKEN;
            ST_WOKEN: begin
                if (!stby_enable)    state_d = ST_RUN;
                else if (reach_mark) state_d = ST_SLEEP;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run        = 1'b0;
        set_wovf   = 1'b0;
        ev_restart = 1'b0;
        ev_restby  = 1'b0;
        ev_reset   = 1'b0;
        ev_irq     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run      = tme;
                set_wovf = wrap;
                ev_reset = wrap && mode;
                ev_irq   = wrap && !mode;
            end
            ST_SLEEP:  run = 1'b0;
            ST_SETTLE: begin
                run        = 1'b1;
                ev_restart = wrap;
            end
            ST_WOKEN: begin
                run       = stby_enable;
                ev_restby = reach_mark;
            end
            default: run = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_restart_req <= 1'b0;
            restby_req      <= 1'b0;
            reset_req       <= 1'b0;
            intv_irq        <= 1'b0;
        end else begin
            clk_restart_req <= ev_restart;
            restby_req      <= ev_restby;
            reset_req       <= ev_reset;
            intv_irq        <= ev_irq;
        end
    end

    // R4 R7: at most one request per cycle
    assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clk_restart_req, restby_req, reset_req, intv_irq}));

    // R7: a restart request is always followed into the post-wake state
    assert_restart_woken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_restart_req |-> (state_q == ST_WOKEN));

    // R8: the re-entry request always lands in standby
    assert_restby_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restby_req |-> (state_q == ST_SLEEP));
endmodule

// File: rtl/wdt_standby_timer.sv
module wdt_standby_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int KEY_W    = 8,
    parameter int NUM_TAPS = 8,
    localparam int CKS_W   = $clog2(NUM_TAPS),
    localparam int DATA_W  = KEY_W + CNT_W,
    localparam int PAD_W   = CNT_W - 3 - CKS_W,
    localparam logic [CNT_W-1:0] MARK = {1'b1, {(CNT_W-1){1'b0}}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_wr,
    input  logic                csr_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_TAPS-1:0] tap_pulse,
    input  logic                wake_req,
    input  logic                stby_active,
    input  logic                stby_enable,
    input  logic                reset_wake,
    output logic [CNT_W-1:0]    cnt_value,
    output logic [CNT_W-1:0]    csr_value,
    output logic                clk_restart_req,
    output logic                restby_req,
    output logic                reset_req,
    output logic                intv_irq
);
    logic             tick, wake_edge, run, advance, set_wovf, cnt_hit;
    logic             wovf, mode, tme;
    logic [CKS_W-1:0] cks;
    logic [CNT_W-1:0] cnt;
    wdt_state_e       state_q;

    wdt_tick_sel #(.NUM_TAPS(NUM_TAPS)) u_tick (
        .clk(clk), .rst_n(rst_n), .taps(tap_pulse), .cks(cks),
        .wake_in(wake_req), .tick(tick), .wake_edge(wake_edge)
    );

    wdt_regs #(.CNT_W(CNT_W), .KEY_W(KEY_W), .CKS_W(CKS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .csr_wr(csr_wr),
        .wdata(wdata), .advance(advance), .set_wovf(set_wovf),
        .cnt_hit(cnt_hit), .cnt(cnt), .wovf(wovf), .mode(mode),
        .tme(tme), .cks(cks)
    );

    wdt_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stby_active(stby_active),
        .stby_enable(stby_enable), .wake_edge(wake_edge),
        .rst_wake(reset_wake), .tick(tick), .cnt_hit(cnt_hit), .cnt(cnt),
        .tme(tme), .mode(mode), .run(run), .advance(advance),
        .set_wovf(set_wovf), .state_q(state_q),
        .clk_restart_req(clk_restart_req), .restby_req(restby_req),
        .reset_req(reset_req), .intv_irq(intv_irq)
    );

    assign cnt_value = cnt;
    assign csr_value = {wovf, mode, tme, {PAD_W{1'b0}}, cks};

    // R4: a watchdog reset always comes with the flag set
    assert_reset_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> wovf);

    // R7: a wakeup wrap leaves the counter at zero without raising the flag
    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_restart_req |-> (cnt == '0 && !$rose(wovf)));

    // R8: re-entry is requested exactly when the count reaches the mark
    assert_restby_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restby_req |-> (cnt == MARK));

    // R6: in standby the counter moves only through a keyed write
    assert_sleep_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !cnt_hit) |=> (cnt == $past(cnt)));
endmodule

// File: tb/wdt_standby_timer_tb.sv
module wdt_standby_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0, csr_wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [7:0]  tap_pulse = '0;
    logic        wake_req = 1'b0, stby_active = 1'b0, stby_enable = 1'b1, reset_wake = 1'b0;
    logic [7:0]  cnt_value, csr_value;
    logic        clk_restart_req, restby_req, reset_req, intv_irq;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    wdt_standby_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .csr_wr(csr_wr),
        .wdata(wdata), .tap_pulse(tap_pulse), .wake_req(wake_req),
        .stby_active(stby_active), .stby_enable(stby_enable),
        .reset_wake(reset_wake), .cnt_value(cnt_value), .csr_value(csr_value),
        .clk_restart_req(clk_restart_req), .restby_req(restby_req),
        .reset_req(reset_req), .intv_irq(intv_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] reqs();
        return {clk_restart_req, restby_req, reset_req, intv_irq};
    endfunction

    task automatic wr_cnt(input logic [15:0] d);
        @(negedge clk); cnt_wr = 1'b1; wdata = d;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic wr_csr(input logic [15:0] d);
        @(negedge clk); csr_wr = 1'b1; wdata = d;
        @(negedge clk); csr_wr = 1'b0;
    endtask

    task automatic tick(input int idx);
        @(negedge clk); tap_pulse[idx] = 1'b1;
        @(negedge clk); tap_pulse = '0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
    endtask

    task automatic t_reset();
        check(cnt_value == 8'h00, "R11 cnt", cnt_value, 0);
        check(csr_value == 8'h00, "R11 csr", csr_value, 0);
        check(reqs() == 4'b0, "R11 reqs", reqs(), 0);
    endtask

    task automatic t_keys();
        wr_cnt(16'h5A33);
        check(cnt_value == 8'h33, "R1 keyed load", cnt_value, 8'h33);
        wr_cnt(16'h1277);
        check(cnt_value == 8'h33, "R1 wrong key", cnt_value, 8'h33);
        wr_csr(16'hA5FF);
        check(csr_value == 8'h67, "R2 layout/R5 write-one", csr_value, 8'h67);
        wr_csr(16'h5A00);
        check(csr_value == 8'h67, "R2 wrong key", csr_value, 8'h67);
        wr_csr(16'hA500);
    endtask

    task automatic t_count();
        wr_cnt(16'h5A10);
        wr_csr(16'hA522);
        tick(1);
        check(cnt_value == 8'h10, "R3 other tap", cnt_value, 8'h10);
        tick(2);
        tick(2);
        check(cnt_value == 8'h12, "R3 selected tap", cnt_value, 8'h12);
        wr_csr(16'hA502);
        tick(2);
        check(cnt_value == 8'h12, "R3 disabled", cnt_value, 8'h12);
    endtask

    task automatic t_overflow();
        wr_cnt(16'h5AFE);
        wr_csr(16'hA563);
        tick(3);
        check(reqs() == 4'b0 && cnt_value == 8'hFF, "R4 pre-wrap", reqs(), 0);
        tick(3);
        check(reset_req && !intv_irq, "R4 watchdog reset", reqs(), 4'b0010);
        check(csr_value == 8'hE3, "R4 flag set", csr_value, 8'hE3);
        @(negedge clk);
        check(reqs() == 4'b0, "R4 one cycle", reqs(), 0);
        wr_csr(16'hA563);
        check(csr_value == 8'h63, "R5 flag clear", csr_value, 8'h63);
        wr_cnt(16'h5AFF);
        wr_csr(16'hA521);
        tick(1);
        check(intv_irq && !reset_req, "R4 interval irq", reqs(), 4'b0001);
        check(csr_value == 8'hA1, "R4 interval flag", csr_value, 8'hA1);
        wr_csr(16'hA521);
        wr_cnt(16'h5AFF);
        // R5: wrap and clearing write in one cycle
        @(negedge clk); tap_pulse[1] = 1'b1; csr_wr = 1'b1; wdata = 16'hA521;
        @(negedge clk); tap_pulse = '0; csr_wr = 1'b0;
        check(csr_value[7] == 1'b1, "R5 set wins", csr_value, 8'hA1);
        wr_csr(16'hA521);
        wr_cnt(16'h5AFF);
        // R12: count pulse and keyed counter write together
        @(negedge clk); tap_pulse[1] = 1'b1; cnt_wr = 1'b1; wdata = 16'h5A10;
        @(negedge clk); tap_pulse = '0; cnt_wr = 1'b0;
        check(cnt_value == 8'h10 && reqs() == 4'b0, "R12 write wins", cnt_value, 8'h10);
        check(csr_value == 8'h21, "R12 no flag", csr_value, 8'h21);
    endtask

    task automatic t_wakeup_reenter();
        int fires = 0;
        wr_csr(16'hA504);
        wr_cnt(16'h5AFD);
        @(negedge clk); stby_active = 1'b1;
        @(negedge clk);
        wr_csr(16'hA524);
        tick(4); tick(4);
        check(cnt_value == 8'hFD, "R6 frozen in standby", cnt_value, 8'hFD);
        wr_csr(16'hA504);
        pulse_wake();
        tick(4); tick(4);
        check(cnt_value == 8'hFF && reqs() == 4'b0, "R7 settling count", cnt_value, 8'hFF);
        tick(4);
        check(clk_restart_req && reqs() == 4'b1000, "R7 restart req", reqs(), 4'b1000);
        check(cnt_value == 8'h00 && csr_value == 8'h04, "R7 no flag", csr_value, 8'h04);
        for (int i = 1; i < 128; i++) begin
            tick(4);
            if (restby_req) fires++;
        end
        check(fires == 0 && cnt_value == 8'h7F, "R8 count to 7F", cnt_value, 8'h7F);
        tick(4);
        check(restby_req && cnt_value == 8'h80, "R8 reenter req", reqs(), 4'b0100);
        tick(4);
        check(cnt_value == 8'h80 && reqs() == 4'b0, "R8 hold in standby", cnt_value, 8'h80);
    endtask

    task automatic t_reset_wake();
        @(negedge clk); stby_active = 1'b0; reset_wake = 1'b1;
        @(negedge clk); reset_wake = 1'b0;
        check(cnt_value == 8'h80, "R10 no run", cnt_value, 8'h80);
        pulse_wake();
        tick(4);
        check(cnt_value == 8'h80 && reqs() == 4'b0, "R10 wake ignored", cnt_value, 8'h80);
        wr_csr(16'hA524);
        tick(4);
        check(cnt_value == 8'h81, "R10 back to normal", cnt_value, 8'h81);
    endtask

    task automatic t_wakeup_stop();
        wr_csr(16'hA504);
        wr_cnt(16'h5AFF);
        @(negedge clk); stby_active = 1'b1;
        @(negedge clk);
        pulse_wake();
        tick(4);
        check(clk_restart_req, "R9 restart first", reqs(), 4'b1000);
        @(negedge clk); stby_enable = 1'b0; stby_active = 1'b0;
        @(negedge clk);
        tick(4); tick(4);
        check(cnt_value == 8'h00 && reqs() == 4'b0, "R9 counter stopped", cnt_value, 0);
        wr_csr(16'hA524);
        tick(4);
        check(cnt_value == 8'h01, "R9 normal again", cnt_value, 1);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keys();
        t_count();
        t_overflow();
        t_wakeup_reenter();
        t_reset_wake();
        t_wakeup_stop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule